// File: doc/BRIEF.md
# Reorder Buffer Commit Throttle

This block is the in-order retire stage of an out-of-order core. Micro-ops are written into a circular reorder buffer through an allocation port, each carrying a ready bit, a vector-class flag and flags that mark the first and the last micro-op of its instruction. A completion port sets the ready bit of an entry that is already held in the buffer. In every cycle the block walks the buffer from the head in program order and retires as many micro-ops as a commit-width budget allows.

The budget is charged per instruction for vector-class work. A scalar micro-op always costs one slot. A vector-class micro-op costs one slot only when it is the first micro-op of its instruction, so the following micro-ops of the same instruction retire without cost. The budget is tested before every entry. When the budget is spent, even a free micro-op waits for the next cycle. A fixed number of retire ports caps the work done in one cycle.

Buffer occupancy is tracked by a three-state machine. Its states are EMPTY, PARTIAL and FULL. These transitions are named: EMPTY to PARTIAL on an allocation, PARTIAL to FULL when the next occupancy reaches the depth, FULL to PARTIAL when retirement frees a slot, PARTIAL to EMPTY when the buffer drains, and any state to EMPTY on a flush. A synchronous flush empties the buffer and overrides both allocation and retirement.

Top module: `rob_commit_throttle`

## Requirements
- R1: After reset the buffer is empty (`buf_empty`=1), `alloc_ready`=1, `alloc_idx`=0, no retire pulse is raised and both running totals are 0.
- R2: Entries retire strictly in order from the head. `retire_vld` bit k means the k-th entry from the head retires, so the bits form a run starting at bit 0. The first entry that is not ready ends retirement for the cycle.
- R3: Scalar micro-ops (`alloc_vec`=0) each cost one slot of the commit budget (COMMIT_W, default 4). With enough ready scalar entries, exactly 4 retire per cycle.
- R4: A vector-class micro-op (`alloc_vec`=1) costs one slot only when its start flag `alloc_som` is 1. Later micro-ops of that instruction retire free in the same cycle.
- R5: The budget is tested before each entry is considered. Once the spent count equals COMMIT_W, no further entry retires that cycle, even one that would be free.
- R6: At most PORTS (default 8) micro-ops retire in one cycle, even if the budget is not spent.
- R7: The buffer holds DEPTH (default 16) entries. When it is full, `alloc_ready` is 0 and an allocation attempt stores nothing.
- R8: An entry allocated into an empty buffer raises no retire pulse in its allocation cycle. It retires in the following cycle at the earliest.
- R9: `uop_total` grows by the number of micro-ops retired. `insn_total` grows by the number of retired micro-ops whose end flag `alloc_eom` was 1. Both update at the clock edge that ends the retire cycle.
- R10: While `flush`=1, nothing retires, `alloc_ready` is 0 and the running totals hold. After the flush the buffer is empty and `alloc_idx` is 0.
- R11: A `done_valid` pulse with `done_idx` naming an occupied entry sets that entry's ready bit. It retires once every older entry has retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all entries and pointers |
| alloc_valid | input | 1 | Allocation request |
| alloc_vec | input | 1 | Micro-op is vector class |
| alloc_som | input | 1 | First micro-op of its instruction |
| alloc_eom | input | 1 | Last micro-op of its instruction |
| alloc_rdy | input | 1 | Micro-op already complete when written |
| alloc_ready | output | 1 | Buffer can take an allocation this cycle |
| alloc_idx | output | $clog2(DEPTH) | Slot the next allocation is written to |
| done_valid | input | 1 | Completion pulse |
| done_idx | input | $clog2(DEPTH) | Slot that completed |
| retire_vld | output | PORTS | Per-port retire pulses, bit 0 is the head |
| retire_uops | output | $clog2(PORTS+1) | Micro-ops retiring this cycle |
| retire_insns | output | $clog2(PORTS+1) | Instructions ending this cycle |
| buf_empty | output | 1 | Buffer holds no entries |
| uop_total | output | CNT_W | Running count of retired micro-ops |
| insn_total | output | CNT_W | Running count of retired instructions |

## Verification
The retire outputs depend only on registered buffer state. A completion or allocation sampled at one rising edge is reflected in `retire_vld`, `retire_uops` and `retire_insns` during the cycle after that edge, and the head pointer and running totals change at the next edge. The driver pushes the expected per-cycle retire counts right after the edge that makes entries ready. The monitor pops one expected item at each falling edge, so every item lands on the cycle it describes. Flush, full and same-cycle-allocation checks are made at the falling edge of the cycle in which the stimulus is held, and again one edge later.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;

    typedef struct packed {
        logic rdy;
        logic vec;
        logic som;
        logic eom;
    } rob_uop_t;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;

endpackage

// File: rtl/rob_commit_ring.sv
module rob_commit_ring
    import rob_commit_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PORTS  = 8,
    parameter int RCNT_W = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 alloc_valid,
    input  rob_uop_t             alloc_uop,
    output logic                 alloc_ready,
    output logic [PTR_W-1:0]     alloc_idx,
    input  logic                 done_valid,
    input  logic [PTR_W-1:0]     done_idx,
    input  logic [RCNT_W-1:0]    retire_n,
    output rob_uop_t [PORTS-1:0] win,
    output logic [OCC_W-1:0]     occ,
    output logic                 buf_empty
);

    rob_uop_t          slots [DEPTH];
    logic [OCC_W-1:0]  head_q, tail_q;
    logic [PTR_W-1:0]  head_idx, done_off;
    logic [OCC_W-1:0]  occ_next;
    logic              alloc_fire, done_hit;
    occ_state_e        state_q, state_d;

    assign head_idx   = head_q[PTR_W-1:0];
    assign alloc_idx  = tail_q[PTR_W-1:0];
    assign occ        = tail_q - head_q;
    assign alloc_fire = alloc_valid && alloc_ready;
    assign done_off   = done_idx - head_idx;
    assign done_hit   = done_valid && ({1'b0, done_off} < occ);

    // Window of the oldest PORTS entries, head first
    for (genvar k = 0; k < PORTS; k++) begin : g_win
        assign win[k] = slots[head_idx + PTR_W'(k)];
    end

    // Entry storage and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (flush) begin
            head_q <= '0;
            tail_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i].rdy <= 1'b0;
        end else begin
            head_q <= head_q + OCC_W'(retire_n);
            if (done_hit) slots[done_idx].rdy <= 1'b1;
            if (alloc_fire) begin
                slots[alloc_idx] <= alloc_uop;
                tail_q           <= tail_q + OCC_W'(1);
            end
        end
    end

    always_comb begin
        occ_next = occ - OCC_W'(retire_n) + OCC_W'(alloc_fire);
    end

    // Occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // Occupancy transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (alloc_fire) state_d = OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (flush)                           state_d = OCC_EMPTY;
                else if (occ_next == OCC_W'(DEPTH))  state_d = OCC_FULL;
                else if (occ_next == '0)             state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (flush)                           state_d = OCC_EMPTY;
                else if (occ_next != OCC_W'(DEPTH))  state_d = OCC_PARTIAL;
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // Outputs of the occupancy machine
    always_comb begin
        alloc_ready = (state_q != OCC_FULL) && !flush;
        buf_empty   = (state_q == OCC_EMPTY);
    end

endmodule

// File: rtl/rob_commit_scan.sv
module rob_commit_scan
    import rob_commit_pkg::*;
#(
    parameter int PORTS    = 8,
    parameter int COMMIT_W = 4,
    parameter int RCNT_W   = 4,
    parameter int OCC_W    = 5
) (
    input  logic                 flush,
    input  rob_uop_t [PORTS-1:0] win,
    input  logic [OCC_W-1:0]     occ,
    output logic [PORTS-1:0]     retire_vld,
    output logic [RCNT_W-1:0]    retire_n,
    output logic [RCNT_W-1:0]    insn_n
);

    logic [RCNT_W-1:0] spent;
    logic              halt;

    always_comb begin
        retire_vld = '0;
        retire_n   = '0;
        insn_n     = '0;
        spent      = '0;
        halt       = flush;
        for (int k = 0; k < PORTS; k++) begin
            if (!halt) begin
                if ((OCC_W'(k) < occ) && win[k].rdy &&
                    (spent < RCNT_W'(COMMIT_W))) begin
                    retire_vld[k] = 1'b1;
                    retire_n      = retire_n + RCNT_W'(1);
                    if (win[k].eom) insn_n = insn_n + RCNT_W'(1);
                    if (!win[k].vec || win[k].som) spent = spent + RCNT_W'(1);
                end else begin
                    halt = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rob_commit_tally.sv
module rob_commit_tally #(
    parameter int RCNT_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RCNT_W-1:0] retire_n,
    input  logic [RCNT_W-1:0] insn_n,
    output logic [CNT_W-1:0]  uop_total,
    output logic [CNT_W-1:0]  insn_total
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uop_total  <= '0;
            insn_total <= '0;
        end else begin
            uop_total  <= uop_total  + CNT_W'(retire_n);
            insn_total <= insn_total + CNT_W'(insn_n);
        end
    end

endmodule

// File: rtl/rob_commit_throttle.sv
module rob_commit_throttle
    import rob_commit_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int COMMIT_W = 4,
    parameter int PORTS    = 8,
    parameter int CNT_W    = 32,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int RCNT_W  = $clog2(PORTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic              alloc_vec,
    input  logic              alloc_som,
    input  logic              alloc_eom,
    input  logic              alloc_rdy,
    output logic              alloc_ready,
    output logic [PTR_W-1:0]  alloc_idx,
    input  logic              done_valid,
    input  logic [PTR_W-1:0]  done_idx,
    output logic [PORTS-1:0]  retire_vld,
    output logic [RCNT_W-1:0] retire_uops,
    output logic [RCNT_W-1:0] retire_insns,
    output logic              buf_empty,
    output logic [CNT_W-1:0]  uop_total,
    output logic [CNT_W-1:0]  insn_total
);

    localparam int OCC_W = PTR_W + 1;

    rob_uop_t             new_uop;
    rob_uop_t [PORTS-1:0] win;
    logic [OCC_W-1:0]     occ;

    assign new_uop = '{rdy: alloc_rdy, vec: alloc_vec, som: alloc_som, eom: alloc_eom};

    rob_commit_ring #(
        .DEPTH  (DEPTH),
        .PORTS  (PORTS),
        .RCNT_W (RCNT_W)
    ) i_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .alloc_valid (alloc_valid),
        .alloc_uop   (new_uop),
        .alloc_ready (alloc_ready),
        .alloc_idx   (alloc_idx),
        .done_valid  (done_valid),
        .done_idx    (done_idx),
        .retire_n    (retire_uops),
        .win         (win),
        .occ         (occ),
        .buf_empty   (buf_empty)
    );

    rob_commit_scan #(
        .PORTS    (PORTS),
        .COMMIT_W (COMMIT_W),
        .RCNT_W   (RCNT_W),
        .OCC_W    (OCC_W)
    ) i_scan (
        .flush      (flush),
        .win        (win),
        .occ        (occ),
        .retire_vld (retire_vld),
        .retire_n   (retire_uops),
        .insn_n     (retire_insns)
    );

    rob_commit_tally #(
        .RCNT_W (RCNT_W),
        .CNT_W  (CNT_W)
    ) i_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_n   (retire_uops),
        .insn_n     (retire_insns),
        .uop_total  (uop_total),
        .insn_total (insn_total)
    );

endmodule

// File: rtl/rob_commit_throttle_chk.sv
module rob_commit_throttle_chk #(
    parameter int PORTS  = 8,
    parameter int RCNT_W = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [PORTS-1:0]  retire_vld,
    input logic [RCNT_W-1:0] retire_uops,
    input logic [RCNT_W-1:0] retire_insns,
    input logic              buf_empty,
    input logic [CNT_W-1:0]  uop_total,
    input logic [CNT_W-1:0]  insn_total
);

    // R2: retire pulses form a run from the head
    a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld & (retire_vld + PORTS'(1))) == '0);

    // R4: instruction ends never outnumber retired micro-ops
    a_r4_insn_bound: assert property (@(posedge clk) disable iff (!rst_n)
        retire_insns <= retire_uops);

    // R8: empty buffer raises no retire pulse
    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> retire_vld == '0);

    // R9: running totals follow the per-cycle counts
    a_r9_uop_total: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> uop_total == $past(uop_total) + CNT_W'($past(retire_uops)));

    a_r9_insn_total: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> insn_total == $past(insn_total) + CNT_W'($past(retire_insns)));

    // R10: flush blocks retirement and empties the buffer
    a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> retire_vld == '0);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> buf_empty);

endmodule

bind rob_commit_throttle rob_commit_throttle_chk #(
    .PORTS  (PORTS),
    .RCNT_W (RCNT_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .retire_vld   (retire_vld),
    .retire_uops  (retire_uops),
    .retire_insns (retire_insns),
    .buf_empty    (buf_empty),
    .uop_total    (uop_total),
    .insn_total   (insn_total)
);

// File: tb/test_rob_commit_throttle.sv
module test_rob_commit_throttle;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PTR_W      = $clog2(DEPTH);
    localparam int PORTS      = 8;
    localparam int RCNT_W     = $clog2(PORTS + 1);
    localparam int CNT_W      = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush;
    logic              alloc_valid, alloc_vec, alloc_som, alloc_eom, alloc_rdy;
    logic              alloc_ready;
    logic [PTR_W-1:0]  alloc_idx;
    logic              done_valid;
    logic [PTR_W-1:0]  done_idx;
    logic [PORTS-1:0]  retire_vld;
    logic [RCNT_W-1:0] retire_uops, retire_insns;
    logic              buf_empty;
    logic [CNT_W-1:0]  uop_total, insn_total;

    rob_commit_throttle i_rob_commit_throttle (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .alloc_valid  (alloc_valid),
        .alloc_vec    (alloc_vec),
        .alloc_som    (alloc_som),
        .alloc_eom    (alloc_eom),
        .alloc_rdy    (alloc_rdy),
        .alloc_ready  (alloc_ready),
        .alloc_idx    (alloc_idx),
        .done_valid   (done_valid),
        .done_idx     (done_idx),
        .retire_vld   (retire_vld),
        .retire_uops  (retire_uops),
        .retire_insns (retire_insns),
        .buf_empty    (buf_empty),
        .uop_total    (uop_total),
        .insn_total   (insn_total)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    uops;
        int    insns;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   tot_uops = 0;
    int   tot_insns = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Scoreboard driver side: expected retire counts for one cycle
    task automatic push_exp(input int u, input int i, input string tag);
        exp_t e;
        e.uops = u;
        e.insns = i;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " retire_uops"}, retire_uops, e.uops);
            chk({e.tag, " retire_insns"}, retire_insns, e.insns);
            chk({e.tag, " retire_vld R2"}, retire_vld, (1 << e.uops) - 1);
            tot_uops  += e.uops;
            tot_insns += e.insns;
        end
    end

    // All tasks are entered and left just after a rising edge
    task automatic alloc(input logic v, input logic s, input logic e, input logic r,
                         output logic [PTR_W-1:0] idx);
        idx = alloc_idx;
        alloc_valid = 1'b1;
        alloc_vec = v;
        alloc_som = s;
        alloc_eom = e;
        alloc_rdy = r;
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic release_slot(input logic [PTR_W-1:0] idx);
        done_valid = 1'b1;
        done_idx = idx;
        @(posedge clk); #1;
        done_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic chk_totals(input string tag);
        chk({tag, " uop_total R9"}, uop_total, tot_uops);
        chk({tag, " insn_total R9"}, insn_total, tot_insns);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        logic [PTR_W-1:0] g, b, unused;
        rst_n = 1'b0;
        flush = 1'b0;
        alloc_valid = 1'b0;
        alloc_vec = 1'b0;
        alloc_som = 1'b0;
        alloc_eom = 1'b0;
        alloc_rdy = 1'b0;
        done_valid = 1'b0;
        done_idx = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 alloc_idx", alloc_idx, 0);
        chk("R1 retire_vld", retire_vld, 0);
        chk("R1 uop_total", uop_total, 0);
        chk("R1 insn_total", insn_total, 0);
        @(posedge clk); #1;

        // R8: allocation into empty buffer does not retire in its own cycle
        alloc_valid = 1'b1; alloc_vec = 1'b0; alloc_som = 1'b1;
        alloc_eom = 1'b1; alloc_rdy = 1'b1;
        @(negedge clk);
        chk("R8 same cycle retire_uops", retire_uops, 0);
        @(posedge clk); #1;
        alloc_valid = 1'b0;
        @(negedge clk);
        chk("R8 next cycle retire_uops", retire_uops, 1);
        tot_uops += 1; tot_insns += 1;
        @(posedge clk); #1;
        chk_totals("R8");

        // R3: scalar budget of four per cycle
        alloc(1'b0, 1'b1, 1'b1, 1'b0, g);
        for (int n = 0; n < 5; n++) alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        release_slot(g);
        push_exp(4, 4, "R3 first");
        push_exp(2, 2, "R3 second");
        wait_drain();
        chk_totals("R3");

        // R4 / R5: vector instructions charged once, budget tested per entry
        alloc(1'b0, 1'b1, 1'b1, 1'b0, g);
        for (int n = 0; n < 3; n++) begin
            alloc(1'b1, 1'b1, 1'b0, 1'b1, unused);
            alloc(1'b1, 1'b0, 1'b1, 1'b1, unused);
        end
        alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        release_slot(g);
        push_exp(6, 3, "R4 free continuation");
        push_exp(2, 2, "R5 budget stop");
        wait_drain();
        chk_totals("R4");

        // R6: port cap on a long vector instruction
        alloc(1'b1, 1'b1, 1'b0, 1'b0, g);
        for (int n = 0; n < 8; n++) alloc(1'b1, 1'b0, 1'b0, 1'b1, unused);
        alloc(1'b1, 1'b0, 1'b1, 1'b1, unused);
        release_slot(g);
        push_exp(8, 0, "R6 cap");
        push_exp(2, 1, "R6 rest");
        wait_drain();
        chk_totals("R6");

        // R2 / R11: not-ready entry blocks younger ones until completed
        alloc(1'b0, 1'b1, 1'b1, 1'b0, g);
        alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        alloc(1'b0, 1'b1, 1'b1, 1'b0, b);
        alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        release_slot(g);
        push_exp(2, 2, "R2 stop at not ready");
        push_exp(0, 0, "R2 blocked");
        wait_drain();
        release_slot(b);
        push_exp(2, 2, "R11 completion");
        wait_drain();
        chk_totals("R11");

        // R7: full buffer refuses allocation
        do_flush();
        chk("R10 alloc_idx after flush", alloc_idx, 0);
        alloc(1'b0, 1'b1, 1'b1, 1'b0, g);
        for (int n = 0; n < DEPTH - 1; n++) alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        @(negedge clk);
        chk("R7 alloc_ready when full", alloc_ready, 0);
        alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        release_slot(g);
        for (int n = 0; n < 4; n++) push_exp(4, 4, "R7 drain");
        push_exp(0, 0, "R7 refused entry absent");
        wait_drain();
        chk("R7 buf_empty", buf_empty, 1);
        chk_totals("R7");

        // R10: flush overrides retirement and allocation
        alloc(1'b0, 1'b1, 1'b1, 1'b0, g);
        for (int n = 0; n < 3; n++) alloc(1'b0, 1'b1, 1'b1, 1'b1, unused);
        release_slot(g);
        flush = 1'b1;
        alloc_valid = 1'b1; alloc_vec = 1'b0; alloc_som = 1'b1;
        alloc_eom = 1'b1; alloc_rdy = 1'b1;
        @(negedge clk);
        chk("R10 retire_uops during flush", retire_uops, 0);
        chk("R10 alloc_ready during flush", alloc_ready, 0);
        @(posedge clk); #1;
        flush = 1'b0;
        alloc_valid = 1'b0;
        @(negedge clk);
        chk("R10 buf_empty", buf_empty, 1);
        chk("R10 retire_uops after", retire_uops, 0);
        chk("R10 alloc_idx", alloc_idx, 0);
        chk_totals("R10");
        @(posedge clk); #1;

        finish_run();
    end

endmodule